// File: doc/BRIEF.md
# Gaussian channel noise source with SNR scaling

This block adds white Gaussian noise to a stream of complex baseband symbols inside a hardware channel emulator. The noise is not computed per sample. It comes from a pool of 256 signed fixed-point normal variates that is mixed continuously. On every enabled clock, a 32-bit LFSR picks four pool entries, one from each quarter of the pool. A 4-point orthogonal transform built only from adders and a shift mixes the four values, and the four results are written back. Two of the four fresh values become the in-phase and quadrature noise for that clock. The pool is loaded at reset from a computed set of values with standard deviation one, where unit variance corresponds to 1024 LSB. Because the transform preserves energy, the standard deviation stays at one.

Each raw noise value is multiplied by an unsigned Q4.12 scale that software derives from the target SNR. The product is rounded to nearest, saturated to the symbol width and added to the incoming symbol with a saturating adder. The result is presented three clock cycles after the symbol, together with its valid flag.

Top module: `gauss_noise_chan`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `valid_o` is 0 and both symbol outputs are 0.
- R2: `valid_o` repeats `valid_i` three clock cycles later. Outputs leave in the same order the symbols arrived.
- R3: A symbol captured while `en_i` is 0 reaches the output unchanged on both I and Q.
- R4: A symbol whose scale (sampled one cycle after the symbol) is 0 reaches the output unchanged.
- R5: With `en_i` high and scale 0x1000 (1.0), the added noise on each channel has a mean within ±150 LSB of zero and a standard deviation between 800 and 1300 LSB.
- R6: Scale 0x0800 (0.5) gives a noise standard deviation between 0.35 and 0.65 times that measured at 1.0.
- R7: The scaled noise is rounded to the nearest integer. At scale 0x0001, the noise magnitude never exceeds 8, and its mean stays within ±0.2 LSB.
- R8: The noisy sum saturates to the signed 16-bit range without wrapping. With I=+32000, Q=-32000 and scale 0xFFFF, I never drops below -768 and Q never rises above +767. At least 30 % of the samples clip to +32767 (I) and -32768 (Q).
- R9: I and Q noise are drawn from different pool values: their correlation coefficient is below 0.2 in magnitude.
- R10: Whenever `valid_o` is 0, both symbol outputs are 0.
- R11: A new noise value is produced on every enabled clock. Fewer than 5 % of back-to-back samples repeat the previous noise value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; reloads the pool |
| en_i | input | 1 | Noise enable; when low the pool is frozen and zero noise is added |
| scale_i | input | 16 | Unsigned Q4.12 noise amplitude derived from SNR |
| valid_i | input | 1 | Input symbol valid |
| i_sym_i | input | 16 | In-phase symbol, signed |
| q_sym_i | input | 16 | Quadrature symbol, signed |
| valid_o | output | 1 | Output symbol valid |
| i_sym_o | output | 16 | Noisy in-phase symbol, signed, saturated |
| q_sym_o | output | 16 | Noisy quadrature symbol, signed, saturated |

## Verification
The assertions assume that every input is a known value from the first edge after reset. They also assume that `en_i` and the symbols are meaningful at the edge that captures the symbol, while `scale_i` is taken one edge later. The stimulus applies all inputs a fixed time after the rising edge. It also holds the scale constant through each phase and through a six-cycle drain, so every symbol sees one well-defined scale. The statistical checks use thousands of samples per phase, and their limits are set far enough from the nominal values that normal pool fluctuation cannot trip them.

// File: rtl/gauss_noise_pkg.sv
package gauss_noise_pkg;
  // unit variance = 1024 LSB; seeds are a permuted uniform ramp of std ~1.0
  function automatic int pool_seed(int idx, int depth);
    int step;
    step = 3584 / depth;
    return (((idx * 73) % depth) - depth / 2) * step;
  endfunction
endpackage

// File: rtl/gn_lfsr.sv
module gn_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h5EED_C0DE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_o <= SEED;
    else if (en_i) state_o <= (state_o >> 1) ^ (state_o[0] ? TAPS : '0);
  end
endmodule

// File: rtl/gn_pool.sv
module gn_pool #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  parameter int RW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [RW-1:0]       rnd_i,
  output logic signed [W-1:0] noise_i_o,
  output logic signed [W-1:0] noise_q_o
);
  localparam int BANK_D  = DEPTH / 4;
  localparam int BANK_AW = $clog2(BANK_D);
  localparam int AW      = BANK_AW + 2;
  localparam int SW      = W + 2;
  localparam int UB      = 4 * BANK_AW;

  logic signed [W-1:0]  mem [DEPTH];
  logic [AW-1:0]        addr [4];
  logic signed [W-1:0]  rd [4];
  logic signed [W-1:0]  nx [4];
  logic signed [SW-1:0] sum, half;
  logic                 rnd_bit;

  // one entry per quarter: the four addresses can never collide
  for (genvar k = 0; k < 4; k++) begin : g_tap
    assign addr[k] = {2'(k), rnd_i[k*BANK_AW +: BANK_AW]};
    assign rd[k]   = mem[addr[k]];
    assign nx[k]   = W'(half - SW'(rd[k]));
  end

  // spare LFSR bits give an unbiased rounding of the halved sum
  assign rnd_bit = ^rnd_i[RW-1:UB];
  assign sum  = SW'(rd[0]) + SW'(rd[1]) + SW'(rd[2]) + SW'(rd[3]);
  assign half = (sum + $signed({{(SW-1){1'b0}}, rnd_bit})) >>> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= W'(gauss_noise_pkg::pool_seed(j, DEPTH));
    end else if (en_i) begin
      for (int k = 0; k < 4; k++) mem[addr[k]] <= nx[k];
    end
  end

  assign noise_i_o = nx[0];
  assign noise_q_o = nx[1];
endmodule

// File: rtl/gn_chan.sv
module gn_chan #(
  parameter int SYM_W   = 16,
  parameter int RAW_W   = 16,
  parameter int SCALE_W = 16,
  parameter int FRAC    = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    valid_b_i,
  input  logic signed [SYM_W-1:0] sym_i,
  input  logic signed [RAW_W-1:0] raw_i,
  input  logic [SCALE_W-1:0]      scale_i,
  output logic signed [SYM_W-1:0] sym_o
);
  localparam int PW = RAW_W + SCALE_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (FRAC - 1));
  localparam logic signed [PW-1:0] SMAX = PW'((64'sd1 <<< (SYM_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] SMIN = -SMAX - PW'(1);

  logic signed [SYM_W-1:0] sym_a, sym_b, nse_b, nse_n, sum_sat;
  logic signed [RAW_W-1:0] raw_a;
  logic signed [PW-1:0]    prod, rnd;
  logic signed [SYM_W:0]   acc;

  always_comb begin
    prod = PW'(raw_a) * PW'($signed({1'b0, scale_i}));
    rnd  = (prod + HALF) >>> FRAC;
    if (rnd > SMAX)      nse_n = SYM_W'(SMAX);
    else if (rnd < SMIN) nse_n = SYM_W'(SMIN);
    else                 nse_n = SYM_W'(rnd);
  end

  always_comb begin
    acc = (SYM_W+1)'(sym_b) + (SYM_W+1)'(nse_b);
    if (acc[SYM_W] != acc[SYM_W-1])
      sum_sat = acc[SYM_W] ? {1'b1, {(SYM_W-1){1'b0}}} : {1'b0, {(SYM_W-1){1'b1}}};
    else
      sum_sat = acc[SYM_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_a <= '0; raw_a <= '0;
      sym_b <= '0; nse_b <= '0;
      sym_o <= '0;
    end else begin
      sym_a <= sym_i;
      raw_a <= en_i ? raw_i : '0;
      sym_b <= sym_a;
      nse_b <= nse_n;
      sym_o <= valid_b_i ? sum_sat : '0;
    end
  end
endmodule

// File: rtl/gauss_noise_chan.sv
module gauss_noise_chan #(
  parameter int          SYM_W      = 16,
  parameter int          POOL_W     = 16,
  parameter int          POOL_DEPTH = 256,
  parameter int          SCALE_W    = 16,
  parameter int          SCALE_FRAC = 12,
  parameter int          LFSR_W     = 32,
  parameter logic [31:0] LFSR_SEED  = 32'h5EED_C0DE
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [SCALE_W-1:0]      scale_i,
  input  logic                    valid_i,
  input  logic signed [SYM_W-1:0] i_sym_i,
  input  logic signed [SYM_W-1:0] q_sym_i,
  output logic                    valid_o,
  output logic signed [SYM_W-1:0] i_sym_o,
  output logic signed [SYM_W-1:0] q_sym_o
);
  logic [LFSR_W-1:0]        lfsr;
  logic signed [POOL_W-1:0] raw [2];
  logic signed [SYM_W-1:0]  sym_in [2];
  logic signed [SYM_W-1:0]  sym_out [2];
  logic                     v_a, v_b;

  gn_lfsr #(.W(LFSR_W), .SEED(LFSR_W'(LFSR_SEED))) i_lfsr (
    .clk_i, .rst_ni, .en_i, .state_o(lfsr)
  );

  gn_pool #(.DEPTH(POOL_DEPTH), .W(POOL_W), .RW(LFSR_W)) i_pool (
    .clk_i, .rst_ni, .en_i, .rnd_i(lfsr),
    .noise_i_o(raw[0]), .noise_q_o(raw[1])
  );

  assign sym_in[0] = i_sym_i;
  assign sym_in[1] = q_sym_i;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    gn_chan #(
      .SYM_W(SYM_W), .RAW_W(POOL_W), .SCALE_W(SCALE_W), .FRAC(SCALE_FRAC)
    ) i_chan (
      .clk_i, .rst_ni, .en_i,
      .valid_b_i(v_b),
      .sym_i(sym_in[c]),
      .raw_i(raw[c]),
      .scale_i,
      .sym_o(sym_out[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {v_a, v_b, valid_o} <= '0;
    else         {v_a, v_b, valid_o} <= {valid_i, v_a, v_b};
  end

  assign i_sym_o = sym_out[0];
  assign q_sym_o = sym_out[1];
endmodule

// File: rtl/gauss_noise_chan_chk.sv
module gauss_noise_chan_chk #(
  parameter int SYM_W   = 16,
  parameter int SCALE_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic [SCALE_W-1:0]      scale_i,
  input logic                    valid_i,
  input logic signed [SYM_W-1:0] i_sym_i,
  input logic signed [SYM_W-1:0] q_sym_i,
  input logic                    valid_o,
  input logic signed [SYM_W-1:0] i_sym_o,
  input logic signed [SYM_W-1:0] q_sym_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  p_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && $past(valid_i, 3) && !$past(en_i, 3)) |->
      (i_sym_o == $past(i_sym_i, 3) && q_sym_o == $past(q_sym_i, 3)));

  p_zero_scale_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && $past(valid_i, 3) && $past(scale_i, 2) == '0) |->
      (i_sym_o == $past(i_sym_i, 3) && q_sym_o == $past(q_sym_i, 3)));

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (i_sym_o == '0 && q_sym_o == '0));
endmodule

bind gauss_noise_chan gauss_noise_chan_chk #(.SYM_W(SYM_W), .SCALE_W(SCALE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .scale_i(scale_i),
  .valid_i(valid_i), .i_sym_i(i_sym_i), .q_sym_i(q_sym_i),
  .valid_o(valid_o), .i_sym_o(i_sym_o), .q_sym_o(q_sym_o)
);

// File: tb/test_gauss_noise_chan.sv
module test_gauss_noise_chan;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, valid = 1'b0;
  logic [15:0] scale = '0;
  logic signed [15:0] i_in = '0, q_in = '0;
  logic valid_o;
  logic signed [15:0] i_out, q_out;

  always #10 clk = ~clk;

  gauss_noise_chan i_gauss_noise_chan (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .scale_i(scale),
    .valid_i(valid), .i_sym_i(i_in), .q_sym_i(q_in),
    .valid_o(valid_o), .i_sym_o(i_out), .q_sym_o(q_out)
  );

  int n_run = 0, n_fail = 0;
  bit running = 0;
  int mode = 0;            // 0 exact compare, 1 statistics
  string mode_req = "R3";
  logic [31:0] exp_q[$];
  logic [2:0] vpipe;

  int  st_n, st_eq, st_maxabs, st_imin, st_qmax, st_ihi, st_qlo, prev_di;
  bit  have_prev;
  real s_i, s_i2, s_q, s_q2, s_iq;

  task automatic chk(bit ok, string req, string msg);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic clear_stats();
    st_n = 0; st_eq = 0; st_maxabs = 0; st_ihi = 0; st_qlo = 0;
    st_imin = 40000; st_qmax = -40000; have_prev = 0; prev_di = 0;
    s_i = 0; s_i2 = 0; s_q = 0; s_q2 = 0; s_iq = 0;
  endtask

  // bench model of the valid delay
  always @(posedge clk or negedge rst_n)
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[1:0], valid};

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && running) begin
      chk(valid_o === vpipe[2], "R2", $sformatf("valid_o actual %0b expected %0b", valid_o, vpipe[2]));
      if (valid_o !== 1'b1) begin
        chk(i_out === 16'sd0 && q_out === 16'sd0, "R10",
            $sformatf("idle outputs actual %0d/%0d expected 0/0", i_out, q_out));
      end else if (exp_q.size() == 0) begin
        chk(0, "R2", "output valid actual 1 expected 0 (queue empty)");
      end else begin
        logic [31:0] e;
        int ei, eq, di, dq;
        e  = exp_q.pop_front();
        ei = int'($signed(e[31:16]));
        eq = int'($signed(e[15:0]));
        di = int'(i_out) - ei;
        dq = int'(q_out) - eq;
        if (mode == 0) begin
          chk(di == 0 && dq == 0, mode_req,
              $sformatf("I/Q actual %0d/%0d expected %0d/%0d", i_out, q_out, ei, eq));
        end else begin
          st_n++;
          s_i += di; s_i2 += real'(di) * di;
          s_q += dq; s_q2 += real'(dq) * dq;
          s_iq += real'(di) * dq;
          if (have_prev && di == prev_di) st_eq++;
          prev_di = di; have_prev = 1;
          if (di > st_maxabs) st_maxabs = di;
          if (-di > st_maxabs) st_maxabs = -di;
          if (dq > st_maxabs) st_maxabs = dq;
          if (-dq > st_maxabs) st_maxabs = -dq;
          if (int'(i_out) < st_imin) st_imin = int'(i_out);
          if (int'(q_out) > st_qmax) st_qmax = int'(q_out);
          if (i_out == 16'sd32767) st_ihi++;
          if (q_out == -16'sd32768) st_qlo++;
        end
      end
    end
  end

  // driver
  task automatic drive(bit v, int i, int q);
    @(posedge clk); #5;
    valid = v; i_in = 16'(i); q_in = 16'(q);
    if (v) exp_q.push_back({16'(i), 16'(q)});
  endtask

  task automatic drain();
    repeat (6) drive(0, 0, 0);
  endtask

  function automatic int rnd_sym(int lim);
    return int'($urandom_range(0, 2 * lim)) - lim;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  real m_i, m_q, sd_i, sd_q, sd_ref, r;

  initial begin
    clear_stats();
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    @(negedge clk);
    chk(valid_o === 1'b0 && i_out === 16'sd0 && q_out === 16'sd0, "R1",
        $sformatf("in reset actual v=%0b %0d/%0d expected 0 0/0", valid_o, i_out, q_out));
    @(posedge clk); #5 rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o === 1'b0 && i_out === 16'sd0 && q_out === 16'sd0, "R1",
        $sformatf("after reset actual v=%0b %0d/%0d expected 0 0/0", valid_o, i_out, q_out));
    running = 1;

    // R3: noise disabled, data passes unchanged, gapped valid and extremes
    mode = 0; mode_req = "R3"; en = 0; scale = 16'h1000;
    drive(1, 32767, -32768);
    drive(1, -32768, 32767);
    for (int k = 0; k < 60; k++) drive($urandom_range(0, 3) != 0, rnd_sym(32767), rnd_sym(32767));
    drain();

    // R4: zero scale, data passes unchanged even with the pool mixing
    mode_req = "R4"; en = 1; scale = 16'h0000;
    for (int k = 0; k < 60; k++) drive($urandom_range(0, 3) != 0, rnd_sym(30000), rnd_sym(30000));
    drain();

    // R5, R9, R11: unit scale statistics
    mode = 1; clear_stats(); scale = 16'h1000;
    for (int k = 0; k < 4000; k++) drive(1, rnd_sym(1000), rnd_sym(1000));
    drain();
    m_i = s_i / st_n; m_q = s_q / st_n;
    sd_i = $sqrt(s_i2 / st_n - m_i * m_i);
    sd_q = $sqrt(s_q2 / st_n - m_q * m_q);
    r = (s_iq / st_n - m_i * m_q) / (sd_i * sd_q);
    sd_ref = (sd_i + sd_q) / 2.0;
    chk(st_n == 4000, "R5", $sformatf("sample count actual %0d expected 4000", st_n));
    chk(m_i > -150.0 && m_i < 150.0, "R5", $sformatf("I mean actual %f expected |m|<150", m_i));
    chk(m_q > -150.0 && m_q < 150.0, "R5", $sformatf("Q mean actual %f expected |m|<150", m_q));
    chk(sd_i > 800.0 && sd_i < 1300.0, "R5", $sformatf("I std actual %f expected 800..1300", sd_i));
    chk(sd_q > 800.0 && sd_q < 1300.0, "R5", $sformatf("Q std actual %f expected 800..1300", sd_q));
    chk(r > -0.2 && r < 0.2, "R9", $sformatf("I/Q correlation actual %f expected |r|<0.2", r));
    chk(st_eq * 20 < st_n, "R11", $sformatf("repeated noise actual %0d expected <%0d", st_eq, st_n / 20));

    // R6: half scale
    clear_stats(); scale = 16'h0800;
    for (int k = 0; k < 4000; k++) drive(1, rnd_sym(1000), rnd_sym(1000));
    drain();
    m_i = s_i / st_n; m_q = s_q / st_n;
    sd_i = $sqrt(s_i2 / st_n - m_i * m_i);
    sd_q = $sqrt(s_q2 / st_n - m_q * m_q);
    r = (sd_i + sd_q) / 2.0 / sd_ref;
    chk(r > 0.35 && r < 0.65, "R6", $sformatf("std ratio actual %f expected 0.35..0.65", r));

    // R7: smallest scale, rounding to nearest
    clear_stats(); scale = 16'h0001;
    for (int k = 0; k < 4000; k++) drive(1, rnd_sym(1000), rnd_sym(1000));
    drain();
    m_i = s_i / st_n; m_q = s_q / st_n;
    chk(st_maxabs <= 8, "R7", $sformatf("max |noise| actual %0d expected <=8", st_maxabs));
    chk(m_i > -0.2 && m_i < 0.2, "R7", $sformatf("I mean actual %f expected |m|<0.2", m_i));
    chk(m_q > -0.2 && m_q < 0.2, "R7", $sformatf("Q mean actual %f expected |m|<0.2", m_q));

    // R8: saturation near full scale
    clear_stats(); scale = 16'hFFFF;
    for (int k = 0; k < 2000; k++) drive(1, 32000, -32000);
    drain();
    chk(st_imin >= -768, "R8", $sformatf("I minimum actual %0d expected >= -768", st_imin));
    chk(st_qmax <= 767, "R8", $sformatf("Q maximum actual %0d expected <= 767", st_qmax));
    chk(st_ihi * 10 >= st_n * 3, "R8", $sformatf("I clipped count actual %0d expected >= %0d", st_ihi, st_n * 3 / 10));
    chk(st_qlo * 10 >= st_n * 3, "R8", $sformatf("Q clipped count actual %0d expected >= %0d", st_qlo, st_n * 3 / 10));

    chk(exp_q.size() == 0, "R2", $sformatf("pending items actual %0d expected 0", exp_q.size()));
    summary();
  end
endmodule